// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block produces one output pulse of programmable length, counted in clock cycles, each time a qualified trigger arrives. There are three ways to start a pulse: a high-to-low step on the falling-edge trigger input, a low-to-high step on the rising-edge trigger input, and the release of the active-low clear. Each trigger input also acts as an enable for the other, so one level can gate the edge on the other. A qualified trigger that arrives during a pulse reloads the count, so the pulse ends one full width after the last trigger.

Clear ends a pulse on the spot and blocks the trigger inputs for as long as it is held. After it is released, the trigger inputs stay locked out for a fixed number of cycles. All three control inputs pass through two-flop synchronizers, so the inputs may be asynchronous to the clock. Two instances side by side give a dual timer.

Top module: `retrig_oneshot`

## Requirements
- R1: A high-to-low step on `trig_fall_n` starts a pulse only if, at that moment, `trig_rise` is high, `clr_n` is high and the post-clear lockout is over. `q` rises on the third rising clock edge after the input changes.
- R2: A low-to-high step on `trig_rise` starts a pulse only if, at that moment, `trig_fall_n` is low, `clr_n` is high and the lockout is over. Its latency matches R1.
- R3: A low-to-high step on `clr_n` starts a pulse when `trig_fall_n` is low and `trig_rise` is high. This trigger is not subject to the lockout.
- R4: Rising steps on `trig_fall_n` and falling steps on `trig_rise` never start a pulse. Whenever the block is idle, `q` is 0 and `q_n` is 1.
- R5: Without a retrigger, `q` stays high for exactly `width` clock cycles.
- R6: A qualified trigger during a pulse reloads the count. `q` then stays high for exactly `width` cycles counted from the retrigger.
- R7: A low level on `clr_n` forces `q` low on the third clock edge after the input falls, even partway through a pulse. While `clr_n` stays low, no trigger edge changes the outputs.
- R8: After `clr_n` is released, the trigger edges of R1 and R2 are ignored for `RECOVERY` cycles. A trigger edge seen `RECOVERY` cycles after the release is accepted.
- R9: `width` is sampled only when a trigger is accepted. A change during a pulse does not alter that pulse. A `width` of 0 gives a one-cycle pulse.
- R10: A high `rst` drives `q` low and `q_n` high at the next clock edge, clears the pulse count and ends any lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_n | input | 1 | Trigger input that fires on a falling edge; its low level enables the rising-edge trigger |
| trig_rise | input | 1 | Trigger input that fires on a rising edge; its high level enables the falling-edge trigger |
| clr_n | input | 1 | Clear, active low; its release can also trigger |
| width | input | CW | Pulse length in clock cycles; 0 is treated as 1 |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions observe only the synchronized copies of the inputs. They assume that a change on an input is held long enough for the synchronizer chain to sample it. The stimulus meets this by changing inputs only at falling clock edges and holding every level for at least two cycles. Before each qualification vector, the bench holds reset for four cycles, which lets the synchronizer and edge-history flops (which have no reset) settle to the preset levels. As a result, the vector's own step is the only edge the block sees.

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
  parameter int CW       = 16,
  parameter int RECOVERY = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_fall_n,
  input  logic          trig_rise,
  input  logic          clr_n,
  input  logic [CW-1:0] width,
  output logic          q,
  output logic          q_n
);
  localparam int RW = (RECOVERY > 0) ? $clog2(RECOVERY + 1) : 1;

  logic [2:0]    a_sh, b_sh, c_sh;
  logic          a_s, b_s, clr_s;
  logic          a_fall, b_rise, c_rise;
  logic          ready, ab_trig, clr_trig, trig;
  logic [CW-1:0] w_eff, cnt;
  logic [RW-1:0] rec_cnt;

  always_ff @(posedge clk) begin
    a_sh <= {a_sh[1:0], trig_fall_n};
    b_sh <= {b_sh[1:0], trig_rise};
    c_sh <= {c_sh[1:0], clr_n};
  end

  assign a_s    = a_sh[1];
  assign b_s    = b_sh[1];
  assign clr_s  = c_sh[1];
  assign a_fall = a_sh[2] & ~a_sh[1];
  assign b_rise = ~b_sh[2] & b_sh[1];
  assign c_rise = ~c_sh[2] & c_sh[1];

  assign ready    = (rec_cnt == '0);
  assign ab_trig  = ((a_fall & b_s) | (b_rise & ~a_s)) & clr_s & ready;
  assign clr_trig = c_rise & ~a_s & b_s;
  assign trig     = ab_trig | clr_trig;
  assign w_eff    = (width == '0) ? CW'(1) : width;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      cnt     <= '0;
      rec_cnt <= '0;
    end else begin
      if (!clr_s)
        rec_cnt <= RW'(RECOVERY);
      else if (!ready)
        rec_cnt <= rec_cnt - RW'(1);

      if (!clr_s) begin
        q   <= 1'b0;
        cnt <= '0;
      end else if (trig) begin
        q   <= 1'b1;
        cnt <= w_eff;
      end else if (q) begin
        if (cnt <= CW'(1)) begin
          q   <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  assign q_n = ~q;
endmodule

module retrig_oneshot_chk #(
  parameter int CW = 16,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          q,
  input logic          q_n,
  input logic          clr_s,
  input logic          trig,
  input logic          clr_trig,
  input logic [CW-1:0] cnt,
  input logic [RW-1:0] rec_cnt
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!q && q_n)); // R10
  AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> !q); // R7
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(trig)); // R1
  AST_ACTIVE_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    q |-> (cnt != '0)); // R5
  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (q && clr_s && !trig && cnt > CW'(1)) |=> (q && cnt == $past(cnt) - CW'(1))); // R6
  AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rec_cnt != '0 && !q && !clr_trig) |=> !q); // R8
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .q(q), .q_n(q_n), .clr_s(clr_s), .trig(trig),
  .clr_trig(clr_trig), .cnt(cnt), .rec_cnt(rec_cnt)
);

// File: tb/retrig_oneshot_test.sv
module retrig_oneshot_test;
  localparam int CW  = 8;
  localparam int REC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b1, b = 1'b0, c = 1'b1;
  logic [CW-1:0] w = 8'd40;
  logic q, q_n;
  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  retrig_oneshot #(.CW(CW), .RECOVERY(REC)) uut (
    .clk(clk), .rst(rst), .trig_fall_n(a), .trig_rise(b), .clr_n(c),
    .width(w), .q(q), .q_n(q_n)
  );

  // {a0,b0,c0, a1,b1,c1, expected q}
  localparam logic [6:0] VEC [11] = '{
    7'b111_011_1,  // R1 valid falling step
    7'b101_001_0,  // R1 blocked, rising-edge input low
    7'b110_010_0,  // R7 blocked by clear
    7'b001_011_1,  // R2 valid rising step
    7'b101_111_0,  // R2 blocked, falling-edge input high
    7'b000_010_0,  // R7 blocked by clear
    7'b010_011_1,  // R3 clear release triggers
    7'b110_111_0,  // R3 blocked, falling-edge input high
    7'b000_001_0,  // R3 blocked, rising-edge input low
    7'b011_111_0,  // R4 wrong direction
    7'b011_001_0   // R4 wrong direction
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic preset(input logic pa, input logic pb, input logic pc);
    @(negedge clk);
    a = pa; b = pb; c = pc; rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (q) n++;
      else break;
    end
  endtask

  task automatic fire_a();
    @(negedge clk);
    a = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int n;
    preset(1'b1, 1'b0, 1'b1);
    check(q == 1'b0 && q_n == 1'b1, "R4 reset idle", q, 0);

    for (int i = 0; i < 11; i++) begin
      preset(VEC[i][6], VEC[i][5], VEC[i][4]);
      a = VEC[i][3]; b = VEC[i][2]; c = VEC[i][1];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(q == VEC[i][0], $sformatf("R1-vector %0d q", i), q, VEC[i][0]);
      check(q_n == ~VEC[i][0], $sformatf("R4 vector %0d q_n", i), q_n, !VEC[i][0]);
    end

    // R5 exact width
    w = 8'd5; preset(1'b1, 1'b1, 1'b1);
    fire_a(); count_high(n);
    check(n == 5, "R5 width 5", n, 5);
    w = 8'd13; preset(1'b1, 1'b1, 1'b1);
    fire_a(); count_high(n);
    check(n == 13, "R5 width 13", n, 13);

    // R9 zero width gives one cycle
    w = 8'd0; preset(1'b1, 1'b1, 1'b1);
    fire_a(); count_high(n);
    check(n == 1, "R9 width 0", n, 1);

    // R9 width change mid-pulse ignored
    w = 8'd10; preset(1'b1, 1'b1, 1'b1);
    fire_a(); @(negedge clk);
    w = 8'd2;
    count_high(n);
    check(n == 9, "R9 width change mid-pulse", n, 9);

    // R6 retrigger
    w = 8'd10; preset(1'b1, 1'b1, 1'b1);
    fire_a(); @(negedge clk);
    check(q == 1'b1, "R6 first pulse", q, 1);
    a = 1'b1;
    repeat (2) @(negedge clk);
    a = 1'b0;
    repeat (3) @(posedge clk);
    count_high(n);
    check(n == 10, "R6 retrigger extends", n, 10);

    // R7 clear mid-pulse, triggers ignored while held
    w = 8'd40; preset(1'b1, 1'b1, 1'b1);
    fire_a(); @(negedge clk);
    c = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    check(q == 1'b1, "R7 before clear latency", q, 1);
    @(posedge clk); @(negedge clk);
    check(q == 1'b0, "R7 clear forces low", q, 0);
    a = 1'b1; repeat (2) @(negedge clk);
    a = 1'b0; b = 1'b0; repeat (2) @(negedge clk);
    b = 1'b1; repeat (6) @(negedge clk);
    check(q == 1'b0 && q_n == 1'b1, "R7 triggers ignored during clear", q, 0);

    // R8 lockout: edge one cycle early is ignored
    a = 1'b1; b = 1'b1; repeat (4) @(negedge clk);
    c = 1'b1;
    repeat (REC - 1) @(negedge clk);
    a = 1'b0;
    repeat (8) @(negedge clk);
    check(q == 1'b0, "R8 trigger during lockout", q, 0);

    // R8 lockout: edge right at the end is accepted
    c = 1'b0; a = 1'b1; repeat (4) @(negedge clk);
    c = 1'b1;
    repeat (REC) @(negedge clk);
    a = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    check(q == 1'b1, "R8 trigger after lockout", q, 1);

    // R10 reset mid-pulse
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(q == 1'b0 && q_n == 1'b1, "R10 reset mid-pulse", q, 0);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule